// File: doc/BRIEF.md
# Bus Error Status and Interrupt Register

This block gathers error events from the master and target sides of a PCI bus controller. Each kind of error has a sticky status bit. Software clears a bit by writing a 1 to its position. Only the first error after an all-clear state is kept. An interrupt line is raised whenever a kept error is also enabled in a mask register.

Some error sources are detected inside the block:

- An I/O byte-enable legality check raises a target abort.
- A watchdog watches memory reads that were answered with a retry. It flags a timeout if the master does not come back within 2^15 clocks.

Other errors arrive as one-cycle event pulses. Some of these are gated by configuration bits: bus-master enable, parity-error response and system-error enable.

Software uses one small register port. It selects either the status word or the mask word. A write to the status word clears bits. A write to the mask word replaces the mask. The read data is combinational.

Top module: `bus_err_irq_reg`

## Requirements
- R1: Status bit positions: 15 unlocked master access to a locked target, 14 target abort, 9 memory-read retry timeout, 8 master operation while master disabled, 7 address parity error, 6 system error seen, 5 target-write data parity error, 4 parity error seen on a target read. All other bits of the status and mask words read 0 whatever is written to them. `reg_sel`=0 selects status and `reg_sel`=1 selects mask.
- R2: Writing 1 to an implemented status bit clears it. Writing 0 leaves it unchanged.
- R3: A status bit sets even when its mask bit is 0. `irq` is high exactly while some status bit and its mask bit are both 1.
- R4: Only one error is held. While any status bit is 1, new events are dropped. When several events arrive in the same cycle with status clear, only the highest-numbered bit is set. Once status is all-zero again, capture resumes.
- R5: A master-operation request with `cfg_master_en`=0 sets bit 8. With `cfg_master_en`=1 it sets nothing.
- R6: An address parity event sets bit 7 only when `cfg_parity_resp` and `cfg_serr_en` are both 1. A target-write data parity event sets bit 5 only when `cfg_parity_resp` is 1.
- R7: During a valid I/O transfer, bit 14 sets when any active-low byte enable below the lane selected by `io_addr_lo` is 0. That is, the pattern is illegal if any lane i with i < `io_addr_lo` is enabled. All-disabled patterns, and patterns with no I/O transfer valid, are legal.
- R8: After `mrd_retry_issued`, bit 9 sets on the 2^15-th clock edge after the arming edge, provided `mrd_retry_done` has not arrived.
- R9: A `mrd_retry_done` that arrives on the terminal count, or earlier, disarms the timer with no timeout. Nothing else arms the timer.
- R10: After reset, status and mask are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master_en | input | 1 | Bus-master operations allowed |
| cfg_parity_resp | input | 1 | Parity-error response enable |
| cfg_serr_en | input | 1 | System-error enable |
| ev_unlock_locked | input | 1 | Unlocked master access to a locked target |
| ev_master_req | input | 1 | PIO or DMA master operation requested |
| io_valid | input | 1 | Target I/O transfer data phase |
| io_addr_lo | input | 2 | Low two address bits of the I/O transfer |
| io_be_n | input | 4 | Active-low byte enables |
| mrd_retry_issued | input | 1 | Retry issued on a target memory read |
| mrd_retry_done | input | 1 | Master repeated the retried read |
| ev_addr_perr | input | 1 | Address parity error seen |
| ev_serr | input | 1 | System-error signal seen |
| ev_tw_dperr | input | 1 | Data parity error on a target write |
| ev_tr_perr | input | 1 | Parity error reported on a target read |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 status, 1 mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Level interrupt |

## Verification
A vector table sends one pattern at a time into a clear status word. The patterns cover:

- each ungated event alone;
- each gated event with its enables on, and again with each enable off, which separates the AND gating from a single-enable gate;
- byte-enable patterns at every address offset, including enabled lanes above, at and below the selected lane, which tells a "below" test from an "any" test;
- simultaneous events, which reveal the priority order.

Directed tests then cover:

- holding the first error and dropping later ones;
- clearing on write-one against writing zero;
- masked against unmasked interrupts;
- a timeout at exactly 2^15 edges against a retry arriving on the terminal count.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
  localparam int STAT_W    = 16;
  localparam int B_UNLOCK  = 15;
  localparam int B_TABORT  = 14;
  localparam int B_RETRY   = 9;
  localparam int B_MDIS    = 8;
  localparam int B_APERR   = 7;
  localparam int B_SERR    = 6;
  localparam int B_TWDPERR = 5;
  localparam int B_TRPERR  = 4;
  localparam logic [STAT_W-1:0] IMPL_MASK = 16'hC3F0;
endpackage

// File: rtl/io_be_check.sv
module io_be_check #(
  parameter int LANES = 4,
  localparam int AW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic [AW-1:0]    addr_lo,
  input  logic [LANES-1:0] be_n,
  output logic             illegal
);
  logic [LANES-1:0] below;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign below[i] = (i < int'(addr_lo));
    end
  endgenerate

  always_comb illegal = io_valid && (|(~be_n & below));

  // R7
  lane0_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_lo == '0) |-> !illegal);
  // R7
  no_io_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> !illegal);
endmodule

// File: rtl/retry_watchdog.sv
module retry_watchdog #(
  parameter int CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic retry_issued,
  input  logic retry_done,
  output logic timeout
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             terminal;

  always_comb begin
    terminal = armed_q && (&cnt_q);
    timeout  = terminal && !retry_done;
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    if (retry_issued) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (retry_done || terminal) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (armed_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R9
  done_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_done && !retry_issued) |=> !armed_q);
  // R8
  tmo_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> armed_q);
  // R8
  tmo_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !retry_issued) |=> !armed_q);
endmodule

// File: rtl/err_status_core.sv
module err_status_core
  import bus_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] events,
  input  logic              wr_status,
  input  logic              wr_mask,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq
);
  logic [STAT_W-1:0] status_d, mask_d, pick;
  logic              found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = STAT_W-1; i >= 0; i--) begin
      if (!found && events[i] && IMPL_MASK[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    status_d = status_q;
    if (status_q == '0) status_d = pick;
    else if (wr_status) status_d = status_q & ~(wdata & IMPL_MASK);
    mask_d = wr_mask ? (wdata & IMPL_MASK) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  always_comb irq = |(status_q & mask_q);

  // R4
  one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q));
  // R4
  hold_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0 && !wr_status) |=> $stable(status_q));
  // R2
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && ((status_q & wdata) != '0)) |=> (status_q == '0));
  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: rtl/bus_err_irq_reg.sv
module bus_err_irq_reg
  import bus_err_pkg::*;
#(
  parameter int RETRY_LOG2 = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_master_en,
  input  logic        cfg_parity_resp,
  input  logic        cfg_serr_en,
  input  logic        ev_unlock_locked,
  input  logic        ev_master_req,
  input  logic        io_valid,
  input  logic [1:0]  io_addr_lo,
  input  logic [3:0]  io_be_n,
  input  logic        mrd_retry_issued,
  input  logic        mrd_retry_done,
  input  logic        ev_addr_perr,
  input  logic        ev_serr,
  input  logic        ev_tw_dperr,
  input  logic        ev_tr_perr,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  logic              rst_meta, rst_s_n;
  logic              be_illegal, retry_tmo;
  logic [STAT_W-1:0] events, status_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  io_be_check #(.LANES(4)) u_be (
    .clk(clk), .rst_n(rst_s_n), .io_valid(io_valid),
    .addr_lo(io_addr_lo), .be_n(io_be_n), .illegal(be_illegal)
  );

  retry_watchdog #(.CNT_W(RETRY_LOG2)) u_rtmr (
    .clk(clk), .rst_n(rst_s_n), .retry_issued(mrd_retry_issued),
    .retry_done(mrd_retry_done), .timeout(retry_tmo)
  );

  always_comb begin
    events            = '0;
    events[B_UNLOCK]  = ev_unlock_locked;
    events[B_TABORT]  = be_illegal;
    events[B_RETRY]   = retry_tmo;
    events[B_MDIS]    = ev_master_req && !cfg_master_en;
    events[B_APERR]   = ev_addr_perr && cfg_parity_resp && cfg_serr_en;
    events[B_SERR]    = ev_serr;
    events[B_TWDPERR] = ev_tw_dperr && cfg_parity_resp;
    events[B_TRPERR]  = ev_tr_perr;
  end

  err_status_core u_core (
    .clk(clk), .rst_n(rst_s_n), .events(events),
    .wr_status(reg_wr && !reg_sel), .wr_mask(reg_wr && reg_sel),
    .wdata(reg_wdata[STAT_W-1:0]), .status_q(status_q),
    .mask_q(mask_q), .irq(irq)
  );

  always_comb reg_rdata = {16'h0000, (reg_sel ? mask_q : status_q)};

  // R5
  mdis_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_master_en |=> !$rose(status_q[B_MDIS]));
  // R6
  aperr_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(cfg_parity_resp && cfg_serr_en) |=> !$rose(status_q[B_APERR]));
  // R6
  twd_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cfg_parity_resp |=> !$rose(status_q[B_TWDPERR]));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_rdata & ~{16'h0000, IMPL_MASK}) == 32'h0);
endmodule

// File: tb/bus_err_irq_reg_tb.sv
module bus_err_irq_reg_tb;
  localparam int LIMIT = 1 << 15;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_master_en, cfg_parity_resp, cfg_serr_en;
  logic ev_unlock_locked, ev_master_req, io_valid;
  logic [1:0] io_addr_lo;
  logic [3:0] io_be_n;
  logic mrd_retry_issued, mrd_retry_done;
  logic ev_addr_perr, ev_serr, ev_tw_dperr, ev_tr_perr;
  logic reg_wr, reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_err_irq_reg u_dut (.*);

  // fields: [31:29] cfg {men,per,sen}, [28] unlock, [27] mreq, [26] io,
  // [25:24] addr, [23:20] be_n, [19:16] {aperr,serr,twd,trp}, [15:0] expected
  function automatic logic [31:0] mkv(logic [2:0] c, logic u, logic m, logic io,
                                      logic [1:0] a, logic [3:0] b, logic [3:0] e,
                                      logic [15:0] x);
    return {c, u, m, io, a, b, e, x};
  endfunction

  localparam logic [31:0] VEC [NV] = '{
    mkv(3'd7,1,0,0,2'd0,4'hF,4'h0,16'h8000),
    mkv(3'd3,0,1,0,2'd0,4'hF,4'h0,16'h0100),
    mkv(3'd7,0,1,0,2'd0,4'hF,4'h0,16'h0000),
    mkv(3'd7,0,0,1,2'd2,4'hE,4'h0,16'h4000),
    mkv(3'd7,0,0,1,2'd2,4'h3,4'h0,16'h0000),
    mkv(3'd7,0,0,1,2'd0,4'h0,4'h0,16'h0000),
    mkv(3'd7,0,0,1,2'd3,4'hF,4'h0,16'h0000),
    mkv(3'd7,0,0,1,2'd3,4'h7,4'h0,16'h0000),
    mkv(3'd7,0,0,1,2'd1,4'hD,4'h0,16'h0000),
    mkv(3'd7,0,0,1,2'd3,4'hB,4'h0,16'h4000),
    mkv(3'd7,0,0,0,2'd0,4'hF,4'h8,16'h0080),
    mkv(3'd6,0,0,0,2'd0,4'hF,4'h8,16'h0000),
    mkv(3'd5,0,0,0,2'd0,4'hF,4'h8,16'h0000),
    mkv(3'd7,0,0,0,2'd0,4'hF,4'h4,16'h0040),
    mkv(3'd6,0,0,0,2'd0,4'hF,4'h2,16'h0020),
    mkv(3'd5,0,0,0,2'd0,4'hF,4'h2,16'h0000),
    mkv(3'd7,0,0,0,2'd0,4'hF,4'h1,16'h0010),
    mkv(3'd7,1,0,0,2'd0,4'hF,4'h1,16'h8000),
    mkv(3'd3,0,1,0,2'd0,4'hF,4'h4,16'h0100),
    mkv(3'd7,0,0,1,2'd2,4'hE,4'h8,16'h4000),
    mkv(3'd7,0,0,0,2'd2,4'hE,4'h0,16'h0000)
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_events();
    ev_unlock_locked = 0; ev_master_req = 0; io_valid = 0;
    ev_addr_perr = 0; ev_serr = 0; ev_tw_dperr = 0; ev_tr_perr = 0;
    mrd_retry_issued = 0; mrd_retry_done = 0;
  endtask

  task automatic pulse_unlock();
    ev_unlock_locked = 1'b1;
    @(negedge clk);
    ev_unlock_locked = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0;
    cfg_master_en = 1; cfg_parity_resp = 1; cfg_serr_en = 1;
    io_addr_lo = 0; io_be_n = 4'hF;
    reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    clear_events();
    repeat (3) @(negedge clk);
    rd(0, v); check("R10 status after reset", v, 32'h0);
    rd(1, v); check("R10 mask after reset", v, 32'h0);
    check("R10 irq after reset", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {cfg_master_en, cfg_parity_resp, cfg_serr_en} = VEC[i][31:29];
      ev_unlock_locked = VEC[i][28];
      ev_master_req    = VEC[i][27];
      io_valid         = VEC[i][26];
      io_addr_lo       = VEC[i][25:24];
      io_be_n          = VEC[i][23:20];
      {ev_addr_perr, ev_serr, ev_tw_dperr, ev_tr_perr} = VEC[i][19:16];
      @(negedge clk);
      clear_events();
      rd(0, v);
      check($sformatf("R1 R4 R5 R6 R7 vector %0d", i), v, {16'h0, VEC[i][15:0]});
      check($sformatf("R3 irq masked vector %0d", i), {31'd0, irq}, 32'h0);
      wr(0, 32'hFFFF_FFFF);
    end
    cfg_master_en = 1; cfg_parity_resp = 1; cfg_serr_en = 1;

    // R1 reserved bits of the mask word
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); check("R1 mask readback", v, 32'h0000_C3F0);
    wr(1, 32'h0);

    // R3 status sets while masked, irq follows the mask
    pulse_unlock();
    rd(0, v); check("R3 set while masked", v, 32'h8000);
    check("R3 irq low masked", {31'd0, irq}, 32'h0);
    wr(1, 32'h0000_8000);
    check("R3 irq high unmasked", {31'd0, irq}, 32'h1);

    // R4 later event is dropped
    ev_serr = 1'b1; @(negedge clk); ev_serr = 1'b0;
    rd(0, v); check("R4 second error dropped", v, 32'h8000);

    // R2 write zero and write one elsewhere leave the bit
    wr(0, 32'h0);
    rd(0, v); check("R2 write zero keeps", v, 32'h8000);
    wr(0, 32'hFFFF_7FFF);
    rd(0, v); check("R2 other bits keep", v, 32'h8000);
    check("R3 irq held", {31'd0, irq}, 32'h1);
    wr(0, 32'h0000_8000);
    rd(0, v); check("R2 write one clears", v, 32'h0);
    check("R3 irq drops after clear", {31'd0, irq}, 32'h0);

    // R4 capture re-arms
    ev_serr = 1'b1; @(negedge clk); ev_serr = 1'b0;
    rd(0, v); check("R4 re-armed capture", v, 32'h0040);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h0);

    // R8 timeout at the 2^15-th edge after arming
    mrd_retry_issued = 1'b1; @(negedge clk); mrd_retry_issued = 1'b0;
    repeat (LIMIT - 1) @(negedge clk);
    rd(0, v); check("R8 no timeout one edge early", v, 32'h0);
    @(negedge clk);
    rd(0, v); check("R8 timeout flagged", v, 32'h0200);
    wr(0, 32'h0000_0200);

    // R9 retry on terminal count
    mrd_retry_issued = 1'b1; @(negedge clk); mrd_retry_issued = 1'b0;
    repeat (LIMIT - 1) @(negedge clk);
    mrd_retry_done = 1'b1; @(negedge clk); mrd_retry_done = 1'b0;
    rd(0, v); check("R9 terminal retry no timeout", v, 32'h0);
    repeat (LIMIT + 4) @(negedge clk);
    rd(0, v); check("R9 timer stays idle", v, 32'h0);

    // R9 early retry
    mrd_retry_issued = 1'b1; @(negedge clk); mrd_retry_issued = 1'b0;
    repeat (100) @(negedge clk);
    mrd_retry_done = 1'b1; @(negedge clk); mrd_retry_done = 1'b0;
    repeat (LIMIT + 4) @(negedge clk);
    rd(0, v); check("R9 early retry no timeout", v, 32'h0);

    // R10 reset mid-run clears state
    wr(1, 32'h0000_8000);
    pulse_unlock();
    rst_n = 1'b0;
    #1;
    rd(0, v); check("R10 status cleared by reset", v, 32'h0);
    rd(1, v); check("R10 mask cleared by reset", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule